// File: doc/BRIEF.md
# Buffered Synchronous Serial Port with DMA Request Flags

This block is the data path of a synchronous serial port that buffers one word in each direction. On the transmit side the host writes a word into a holding register. When the serial shifter is free, the word moves into the shifter. The shifter then drives the word onto the serial output, most significant bit first, one bit per bit clock. On the receive side a shifter gathers incoming bits. After a full word it copies them into a data register that the host can read.

Each direction has a ready flag, and that flag is the DMA request. The transmit request is high whenever the holding register can take a new word. The receive request is high whenever an unread word is waiting. Every flag changes on the bit clock. The host port is sampled on that same clock, so a host that polls sees a write take effect one bit clock later.

Each direction has its own enable, and an enable held low keeps that side in reset. Words are sent and received back to back with no framing signal. The receiver starts its first word on the first cycle in which it is enabled.

Top module: `sport_dma_handshake`

## Requirements
- R1: With `rxEnable` high, the receiver takes `serialIn` on every clock, most significant bit first. On the clock that samples the last bit of each `WORD_W`-bit word, the word is copied into `rdData` and `rxEvent` becomes 1.
- R2: `rxEvent` stays 1 until a clock with `rdEn` high and then reads 0. When a read and a copy fall on the same clock, the copy wins and `rxEvent` stays 1.
- R3: While `rxEnable` is low, `rxEvent` and `rxOverrun` read 0 and the receive bit count is cleared. The next enable therefore starts a fresh word.
- R4: `rxOverrun` becomes 1 when a copy happens while `rxEvent` is 1 and the same clock has no read. It then stays 1 until `rxEnable` goes low.
- R5: While `txEnable` is low, `txEvent` is 0. On the first clock on which `txEnable` is high, `txEvent` becomes 1.
- R6: A clock with `wrEn` and `txEnable` both high loads `wrData` into the holding register and clears `txEvent` after that clock. A write while `txEnable` is low has no effect.
- R7: When the shifter is idle and the holding register is full, the word moves into the shifter on the next clock and `txEvent` returns to 1. Its `WORD_W` bits then appear on `serialOut`, most significant bit first, one per clock, starting right after that clock.
- R8: A word written while the shifter is still busy waits in the holding register. Its first bit follows the last bit of the previous word with no gap.
- R9: `serialOut` is 0 whenever the shifter is idle or `txEnable` is low.
- R10: `txOverwrite` becomes 1 after a write accepted while `txEvent` is 0. It then stays 1 until `txEnable` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state and flags change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low device reset |
| txEnable | input | 1 | Transmitter enable; low holds the transmitter in reset |
| rxEnable | input | 1 | Receiver enable; low holds the receiver in reset |
| wrEn | input | 1 | Write strobe for the transmit holding register |
| wrData | input | WORD_W | Word to transmit |
| rdEn | input | 1 | Read strobe for the receive data register |
| rdData | output | WORD_W | Last received word |
| serialIn | input | 1 | Serial receive data |
| serialOut | output | 1 | Serial transmit data |
| txEvent | output | 1 | Transmit DMA request (holding register free) |
| rxEvent | output | 1 | Receive DMA request (unread word waiting) |
| txOverwrite | output | 1 | Sticky: write accepted while holding register full |
| rxOverrun | output | 1 | Sticky: unread received word overwritten |

## Verification
If the transmit bit counter or load strobe is wrong, the fault shows on `serialOut` within one word time. Back-to-back words expose it soonest: a gap bit, a repeated bit or a shifted word appears right at the word boundary. If a ready flag holds a wrong value, `txEvent` or `rxEvent` is wrong on the very next clock. A bad receive count shows as a late or early `rxEvent` and a rotated word on `rdData`. A sticky flag that is set by mistake, or that is not cleared, stays visible until the next disable, so one port sample catches it.

// File: rtl/sport_pkg.sv
package sport_pkg;
  // Strobes from the control unit into the datapath, one clock's worth.
  typedef struct packed {
    logic bufWrite;  // capture host word into holding register
    logic txLoad;    // holding register -> transmit shifter
    logic txShift;   // advance transmit shifter by one bit
    logic txActive;  // shifter is driving a word
    logic rxShift;   // take one serial bit into the receive shifter
    logic rxCopy;    // receive shifter -> host data register
  } sport_strobe_t;
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txEnable,
  input  logic          rxEnable,
  input  logic          wrEn,
  input  logic          rdEn,
  output sport_strobe_t strb,
  output logic          txReady,
  output logic          rxReady,
  output logic          txOvw,
  output logic          rxOvr
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             txPrevEn;
  logic             txBusy;
  logic             txFull;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;
  logic             txLoad;
  logic             rxCopy;

  assign txLoad = txEnable && txFull && (!txBusy || txCnt == LAST);
  assign rxCopy = rxEnable && (rxCnt == LAST);

  always_comb begin
    strb          = '0;
    strb.bufWrite = txEnable && wrEn;
    strb.txLoad   = txLoad;
    strb.txShift  = txEnable && txBusy && !txLoad && (txCnt != LAST);
    strb.txActive = txBusy;
    strb.rxShift  = rxEnable;
    strb.rxCopy   = rxCopy;
  end

  // Transmit side: bit counter, buffer-full, ready and overwrite flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txPrevEn <= 1'b0;
      txBusy   <= 1'b0;
      txFull   <= 1'b0;
      txCnt    <= '0;
      txReady  <= 1'b0;
      txOvw    <= 1'b0;
    end else if (!txEnable) begin
      txPrevEn <= 1'b0;
      txBusy   <= 1'b0;
      txFull   <= 1'b0;
      txCnt    <= '0;
      txReady  <= 1'b0;
      txOvw    <= 1'b0;
    end else begin
      txPrevEn <= 1'b1;
      if (txLoad) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
      end else if (txBusy) begin
        if (txCnt == LAST) txBusy <= 1'b0;
        else               txCnt  <= txCnt + 1'b1;
      end
      if (wrEn)        txFull <= 1'b1;
      else if (txLoad) txFull <= 1'b0;
      if (wrEn)                      txReady <= 1'b0;
      else if (!txPrevEn || txLoad)  txReady <= 1'b1;
      if (wrEn && !txReady) txOvw <= 1'b1;
    end
  end

  // Receive side: bit counter, ready and overrun flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxCnt   <= '0;
      rxReady <= 1'b0;
      rxOvr   <= 1'b0;
    end else if (!rxEnable) begin
      rxCnt   <= '0;
      rxReady <= 1'b0;
      rxOvr   <= 1'b0;
    end else begin
      rxCnt <= (rxCnt == LAST) ? '0 : rxCnt + 1'b1;
      if (rxCopy)    rxReady <= 1'b1;
      else if (rdEn) rxReady <= 1'b0;
      if (rxCopy && rxReady && !rdEn) rxOvr <= 1'b1;
    end
  end
endmodule

// File: rtl/sport_datapath.sv
module sport_datapath
  import sport_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sport_strobe_t     strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              serialIn,
  output logic              serialOut,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] txShifter;
  logic [WORD_W-1:0] rxShifter;
  logic [WORD_W-1:0] rxNext;

  generate
    if (WORD_W > 1) begin : g_wide
      assign rxNext = {rxShifter[WORD_W-2:0], serialIn};
    end else begin : g_single
      assign rxNext = serialIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg   <= '0;
      txShifter <= '0;
      rxShifter <= '0;
      rdData    <= '0;
    end else begin
      if (strb.bufWrite) holdReg <= wrData;
      if (strb.txLoad)       txShifter <= holdReg;
      else if (strb.txShift) txShifter <= txShifter << 1;
      if (strb.rxShift) rxShifter <= rxNext;
      if (strb.rxCopy)  rdData    <= rxNext;
    end
  end

  assign serialOut = strb.txActive && txShifter[WORD_W-1];
endmodule

// File: rtl/sport_dma_handshake.sv
module sport_dma_handshake
  import sport_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic              serialIn,
  output logic              serialOut,
  output logic              txEvent,
  output logic              rxEvent,
  output logic              txOverwrite,
  output logic              rxOverrun
);
  sport_strobe_t strb;

  sport_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
    .wrEn(wrEn), .rdEn(rdEn), .strb(strb), .txReady(txEvent),
    .rxReady(rxEvent), .txOvw(txOverwrite), .rxOvr(rxOverrun)
  );

  sport_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .serialIn(serialIn), .serialOut(serialOut), .rdData(rdData)
  );
endmodule

// File: rtl/sport_checker.sv
module sport_checker (
  input logic clk,
  input logic rst_n,
  input logic txEnable,
  input logic rxEnable,
  input logic wrEn,
  input logic rdEn,
  input logic serialOut,
  input logic txEvent,
  input logic rxEvent,
  input logic txOverwrite,
  input logic rxOverrun
);
  p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rxEvent && rxEnable && !rdEn |=> rxEvent);
  p_rx_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> !rxEvent && !rxOverrun);
  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxOverrun && rxEnable |=> rxOverrun);
  p_tx_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |=> !txEvent && !txOverwrite);
  p_tx_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txEnable && !$past(txEnable) && !wrEn |=> txEvent);
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txEnable && wrEn |=> !txEvent);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |=> !serialOut);
  p_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txEnable && wrEn && !txEvent |=> txOverwrite);
endmodule

bind sport_dma_handshake sport_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
  .wrEn(wrEn), .rdEn(rdEn), .serialOut(serialOut), .txEvent(txEvent),
  .rxEvent(rxEvent), .txOverwrite(txOverwrite), .rxOverrun(rxOverrun)
);

// File: tb/sport_dma_handshake_tb.sv
module sport_dma_handshake_tb;
  localparam int W = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txEnable = 1'b0, rxEnable = 1'b0, wrEn = 1'b0, rdEn = 1'b0, serialIn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic serialOut, txEvent, rxEvent, txOverwrite, rxOverrun;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic done = 1'b0;

  sport_dma_handshake #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .serialIn(serialIn), .serialOut(serialOut), .txEvent(txEvent),
    .rxEvent(rxEvent), .txOverwrite(txOverwrite), .rxOverrun(rxOverrun)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic bitOf(input logic [W-1:0] w, input int i);
    return w[W-1-i];  // MSB first
  endfunction

  // Send one word from an idle transmitter; checks flags and the serial bits.
  task automatic txWord(input logic [W-1:0] w);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    check(txEvent == 1'b0, "R6 write clears txEvent", W'(txEvent), '0);
    @(negedge clk);
    check(txEvent == 1'b1, "R7 copy sets txEvent", W'(txEvent), W'(1));
    for (int i = 0; i < W; i++) begin
      check(serialOut == bitOf(w, i), "R7 serial bit", W'(serialOut), W'(bitOf(w, i)));
      @(negedge clk);
    end
    check(serialOut == 1'b0, "R9 idle output low", W'(serialOut), '0);
  endtask

  // Stream words into the receiver, optionally reading each one.
  task automatic rxStream(input int n, input logic doRead);
    logic [W-1:0] w;
    for (int k = 0; k < n; k++) begin
      w = W'($urandom);
      for (int b = 0; b < W; b++) begin
        serialIn = bitOf(w, b);
        rdEn = (b == 0 && k > 0 && doRead);
        rxEnable = 1'b1;
        @(negedge clk);
        rdEn = 1'b0;
        if (b == 0 && k > 0 && doRead)
          check(rxEvent == 1'b0, "R2 read clears rxEvent", W'(rxEvent), '0);
      end
      check(rxEvent == 1'b1, "R1 rxEvent after word", W'(rxEvent), W'(1));
      check(rdData == w, "R1 received word", rdData, w);
      check(rxOverrun == (k > 0 && !doRead), "R4 overrun flag", W'(rxOverrun),
            W'(k > 0 && !doRead));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(txEvent == 0 && rxEvent == 0 && serialOut == 0 && rdData == 0,
          "R5 reset state", {txEvent, rxEvent, serialOut}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: write while disabled is ignored
    wrEn = 1'b1; wrData = 8'hFF;
    @(negedge clk);
    wrEn = 1'b0;
    check(txEvent == 1'b0, "R5 txEvent low while disabled", W'(txEvent), '0);
    txEnable = 1'b1;
    @(negedge clk);
    check(txEvent == 1'b1, "R5 enable raises txEvent", W'(txEvent), W'(1));
    for (int i = 0; i < W + 2; i++) begin
      check(serialOut == 1'b0, "R6 disabled write not sent", W'(serialOut), '0);
      @(negedge clk);
    end

    // Directed corner words, then random words
    txWord(8'h80);
    txWord(8'h01);
    txWord(8'hA5);
    for (int n = 0; n < 20; n++) txWord(W'($urandom));
    check(txOverwrite == 1'b0, "R10 no false overwrite", W'(txOverwrite), '0);

    // R8: back-to-back words
    begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      wrEn = 1'b1; wrData = a;
      @(negedge clk);
      wrEn = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 2 * W; i++) begin
        logic expBit;
        expBit = (i < W) ? bitOf(a, i) : bitOf(b, i - W);
        check(serialOut == expBit, "R8 back-to-back bit", W'(serialOut), W'(expBit));
        wrEn = (i == 0); wrData = b;
        @(negedge clk);
        wrEn = 1'b0;
        if (i == 0) check(txEvent == 1'b0, "R8 buffered word holds txEvent low",
                          W'(txEvent), '0);
      end
      check(txEvent == 1'b1, "R7 second copy sets txEvent", W'(txEvent), W'(1));
    end
    repeat (2) @(negedge clk);

    // R10: overwrite
    wrEn = 1'b1; wrData = 8'h11;
    @(negedge clk);
    wrData = 8'h22;
    @(negedge clk);
    wrEn = 1'b0;
    check(txOverwrite == 1'b1, "R10 overwrite flagged", W'(txOverwrite), W'(1));
    repeat (3) @(negedge clk);
    check(txOverwrite == 1'b1, "R10 overwrite sticky", W'(txOverwrite), W'(1));
    txEnable = 1'b0;
    @(negedge clk);
    check(txOverwrite == 0 && txEvent == 0 && serialOut == 0,
          "R10 disable clears tx", {txOverwrite, txEvent, serialOut}, '0);

    // Receiver
    rxStream(6, 1'b1);
    rxEnable = 1'b0;
    @(negedge clk);
    check(rxEvent == 1'b0, "R3 disable clears rxEvent", W'(rxEvent), '0);
    rxStream(3, 1'b0);
    rxEnable = 1'b0;
    @(negedge clk);
    check(rxOverrun == 1'b0, "R3 disable clears rxOverrun", W'(rxOverrun), '0);
    // R3: partial word then restart
    rxEnable = 1'b1; serialIn = 1'b1;
    repeat (3) @(negedge clk);
    rxEnable = 1'b0;
    @(negedge clk);
    rxStream(4, 1'b1);
    check(rxEvent == 1'b1, "R2 rxEvent held without read", W'(rxEvent), W'(1));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule